// File: doc/BRIEF.md
# Software-Refilled Two-Way Address Translation Buffer

This block translates a 40-bit virtual address into a 36-bit physical address for 16 KiB pages. It holds 512 translations as 256 sets of two ways. A lookup is captured in a register. During the following cycle the selected set is compared against the stored tags in both ways. A hit returns the physical address, the way, the rights field and the dirty flag. A miss does not start any table walk. It raises a trap output that carries the faulting virtual page number, and privileged software then installs the translation through a one-cycle refill port.

On a hit, the block checks the access against a two-bit rights code. A store to a page whose dirty flag is clear is held back with a modify trap, so that software can note the first write. Each entry also carries a reference flag. A hit sets the flag, a global strobe clears all of them, and a refill that asks the hardware to choose the way uses the flags of the target set. A separate strobe drops every translation in one cycle.

Top module: `sw_tlb`

## Requirements
- R1: The address fields are split as follows: offset = va[13:0], set index = va[21:14], tag = va[39:22]. On a granted hit, rspPa = {stored physical page number, va[13:0]}. When the access is not granted, rspPa is 0.
- R2: An entry is a hit when it is valid and its stored tag equals the tag of the lookup. If both ways of the set match, way 0 is reported. rspWay gives the hitting way, and rspRights and rspDirty give the fields of that entry.
- R3: A request sampled on lkReq at a rising edge produces rspValid = 1 and its result during the next cycle. With no request, rspValid is 0 and rspHit, rspMiss and all fault outputs are 0.
- R4: A lookup that finds no hit asserts rspMiss, puts va[39:14] on rspMissVpn, and keeps rspPaValid at 0.
- R5: The rights codes are 00 none, 01 read-only, 10 read/write and 11 kernel-only. A user access (lkUser = 1) faults on code 00, on code 11, and on a store to code 01. A fault asserts rspProtFault and no address is granted. Kernel accesses are never checked.
- R6: A store that hits an entry whose dirty flag is 0, and has no protection fault, asserts rspModFault and grants no address. A load to the same entry is granted.
- R7: When wrEn is high at a rising edge, the entry at wrSet is written from wrValid, wrDirty, wrRights, wrTag and wrPpn. With wrWayAuto = 0 the way is wrWaySel.
- R8: With wrWayAuto = 1 the refill picks way 0 when the reference flag of way 0 in that set is clear. Otherwise it picks way 1 when its flag is clear. If both flags are set it picks way 0.
- R9: A hit sets the reference flag of the hitting entry, and a refill clears the flag of the entry it writes. When both happen to the same entry in the same cycle, the refill wins.
- R10: clrRef clears every reference flag at the next edge and takes priority over a hit in the same cycle.
- R11: invAll clears every valid flag at the next edge. A refill in the same cycle is lost.
- R12: A lookup whose response cycle coincides with a refill to its own set and way sees the entry being written.
- R13: After reset every entry is invalid, every reference flag is clear, and no response is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| lkReq | input | 1 | Lookup request |
| lkVa | input | 40 | Virtual address to translate |
| lkStore | input | 1 | 1 for a store, 0 for a load |
| lkUser | input | 1 | 1 when the access is in user mode |
| wrEn | input | 1 | Refill write strobe |
| wrSet | input | 8 | Set index of the refill |
| wrWayAuto | input | 1 | Let the hardware choose the way |
| wrWaySel | input | 1 | Explicit way when not automatic |
| wrValid | input | 1 | Valid flag to store |
| wrDirty | input | 1 | Dirty flag to store |
| wrRights | input | 2 | Rights code to store |
| wrTag | input | 18 | Tag to store |
| wrPpn | input | 22 | Physical page number to store |
| invAll | input | 1 | Invalidate every entry |
| clrRef | input | 1 | Clear every reference flag |
| rspValid | output | 1 | A response is shown this cycle |
| rspHit | output | 1 | The lookup hit |
| rspMiss | output | 1 | Miss trap |
| rspMissVpn | output | 26 | Virtual page number of the miss |
| rspProtFault | output | 1 | Protection trap |
| rspModFault | output | 1 | Modify trap, store to a clean page |
| rspPaValid | output | 1 | Access granted and rspPa is valid |
| rspPa | output | 36 | Physical address |
| rspWay | output | 1 | Hitting way |
| rspRights | output | 2 | Rights of the hitting entry |
| rspDirty | output | 1 | Dirty flag of the hitting entry |

## Verification
A corrupted valid flag or tag shows up on the very next lookup of that set, as a wrong rspHit or rspMiss value. A wrong rights or dirty field shows up in the same response as a wrong trap. The reference flags cannot be read directly. A wrong flag shows up only when a later automatic refill of that set puts its entry in the wrong way, and the following lookup then reports an unexpected rspWay. The scenarios therefore follow each flag change with an automatic refill and a lookup of the entry it placed. A faulty forwarding path shows up in the single cycle where a refill and a lookup of the same set overlap.

// File: rtl/sw_tlb_pkg.sv
package sw_tlb_pkg;
  localparam int NUM_WAYS = 2;

  typedef enum logic [1:0] {
    RGT_NONE = 2'b00,
    RGT_RO   = 2'b01,
    RGT_RW   = 2'b10,
    RGT_KERN = 2'b11
  } rights_e;

  // strobes from the control to the entry store
  typedef struct packed {
    logic wrEn;
    logic wrWay;
    logic invAll;
    logic clrRef;
    logic refSetEn;
    logic refWay;
  } tlbStrobe_t;
endpackage

// File: rtl/sw_tlb_store.sv
module sw_tlb_store
  import sw_tlb_pkg::*;
#(
  parameter int SET_W = 8,
  parameter int TAG_W = 18,
  parameter int PPN_W = 22
) (
  input  logic             clk,
  input  logic             rstN,
  input  tlbStrobe_t       strobe,
  input  logic [SET_W-1:0] wrSet,
  input  logic             wrValid,
  input  logic             wrDirty,
  input  logic [1:0]       wrRights,
  input  logic [TAG_W-1:0] wrTag,
  input  logic [PPN_W-1:0] wrPpn,
  input  logic [SET_W-1:0] lkSet,
  input  logic [TAG_W-1:0] lkTag,
  output logic [NUM_WAYS-1:0] hitVec,
  output logic [NUM_WAYS-1:0] wrSetRefs,
  output logic [PPN_W-1:0] hitPpn,
  output logic [1:0]       hitRights,
  output logic             hitDirty
);
  localparam int SETS = 1 << SET_W;

  logic [PPN_W-1:0] wayPpn [NUM_WAYS];
  logic [1:0]       wayRgt [NUM_WAYS];
  logic             wayDirty [NUM_WAYS];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tagMem [SETS];
    logic [PPN_W-1:0] ppnMem [SETS];
    logic [1:0]       rgtMem [SETS];
    logic [SETS-1:0]  dirtyBits;
    logic [SETS-1:0]  validBits;
    logic [SETS-1:0]  refBits;
    logic             thisWr;
    logic             fwd;
    logic             eValid;
    logic [TAG_W-1:0] eTag;

    assign thisWr = strobe.wrEn && (strobe.wrWay == 1'(w));

    always_ff @(posedge clk) begin
      if (thisWr) begin
        tagMem[wrSet]    <= wrTag;
        ppnMem[wrSet]    <= wrPpn;
        rgtMem[wrSet]    <= wrRights;
        dirtyBits[wrSet] <= wrDirty;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              validBits <= '0;
      else if (strobe.invAll) validBits <= '0;
      else if (thisWr)        validBits[wrSet] <= wrValid;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              refBits <= '0;
      else if (strobe.clrRef) refBits <= '0;
      else begin
        if (strobe.refSetEn && (strobe.refWay == 1'(w))) refBits[lkSet] <= 1'b1;
        if (thisWr) refBits[wrSet] <= 1'b0;
      end
    end

    // same-cycle refill of the looked-up set is forwarded
    assign fwd         = thisWr && (wrSet == lkSet);
    assign eValid      = fwd ? wrValid  : validBits[lkSet];
    assign eTag        = fwd ? wrTag    : tagMem[lkSet];
    assign wayPpn[w]   = fwd ? wrPpn    : ppnMem[lkSet];
    assign wayRgt[w]   = fwd ? wrRights : rgtMem[lkSet];
    assign wayDirty[w] = fwd ? wrDirty  : dirtyBits[lkSet];
    assign hitVec[w]   = eValid && (eTag == lkTag);
    assign wrSetRefs[w] = refBits[wrSet];

    a_r11_inv_clears: assert property (@(posedge clk) disable iff (!rstN)
      strobe.invAll |=> (validBits == '0));
    a_r10_ref_clears: assert property (@(posedge clk) disable iff (!rstN)
      strobe.clrRef |=> (refBits == '0));
  end

  always_comb begin
    if (hitVec[0]) begin
      hitPpn = wayPpn[0]; hitRights = wayRgt[0]; hitDirty = wayDirty[0];
    end else begin
      hitPpn = wayPpn[1]; hitRights = wayRgt[1]; hitDirty = wayDirty[1];
    end
  end
endmodule

// File: rtl/sw_tlb_ctrl.sv
module sw_tlb_ctrl
  import sw_tlb_pkg::*;
#(
  parameter int VA_W   = 40,
  parameter int PAGE_W = 14,
  parameter int SET_W  = 8,
  parameter int PPN_W  = 22
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    lkReq,
  input  logic [VA_W-1:0]         lkVa,
  input  logic                    lkStore,
  input  logic                    lkUser,
  input  logic                    wrEn,
  input  logic                    wrWayAuto,
  input  logic                    wrWaySel,
  input  logic                    invAll,
  input  logic                    clrRef,
  input  logic [NUM_WAYS-1:0]     wrSetRefs,
  input  logic [NUM_WAYS-1:0]     hitVec,
  input  logic [PPN_W-1:0]        hitPpn,
  input  logic [1:0]              hitRights,
  input  logic                    hitDirty,
  output tlbStrobe_t              strobe,
  output logic [SET_W-1:0]        lkSet,
  output logic [VA_W-PAGE_W-SET_W-1:0] lkTag,
  output logic                    rspValid,
  output logic                    rspHit,
  output logic                    rspMiss,
  output logic [VA_W-PAGE_W-1:0]  rspMissVpn,
  output logic                    rspProtFault,
  output logic                    rspModFault,
  output logic                    rspPaValid,
  output logic [PPN_W+PAGE_W-1:0] rspPa,
  output logic                    rspWay,
  output logic [1:0]              rspRights,
  output logic                    rspDirty
);
  localparam int PA_W = PPN_W + PAGE_W;

  logic            qValid, qStore, qUser;
  logic [VA_W-1:0] qVa;
  logic            anyHit, userBad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qValid <= 1'b0; qStore <= 1'b0; qUser <= 1'b0; qVa <= '0;
    end else begin
      qValid <= lkReq; qStore <= lkStore; qUser <= lkUser; qVa <= lkVa;
    end
  end

  assign lkSet  = qVa[PAGE_W +: SET_W];
  assign lkTag  = qVa[VA_W-1 : PAGE_W+SET_W];
  assign anyHit = qValid && (hitVec != '0);

  always_comb begin
    case (rights_e'(hitRights))
      RGT_NONE: userBad = 1'b1;
      RGT_RO:   userBad = qStore;
      RGT_RW:   userBad = 1'b0;
      default:  userBad = 1'b1;
    endcase
  end

  assign rspValid     = qValid;
  assign rspHit       = anyHit;
  assign rspMiss      = qValid && !anyHit;
  assign rspMissVpn   = qVa[VA_W-1:PAGE_W];
  assign rspProtFault = anyHit && qUser && userBad;
  assign rspModFault  = anyHit && !rspProtFault && qStore && !hitDirty;
  assign rspPaValid   = anyHit && !rspProtFault && !rspModFault;
  assign rspPa        = rspPaValid ? {hitPpn, qVa[PAGE_W-1:0]} : PA_W'(0);
  assign rspWay       = !hitVec[0];
  assign rspRights    = anyHit ? hitRights : 2'b00;
  assign rspDirty     = anyHit && hitDirty;

  always_comb begin
    strobe.wrEn     = wrEn;
    strobe.invAll   = invAll;
    strobe.clrRef   = clrRef;
    strobe.refSetEn = anyHit;
    strobe.refWay   = !hitVec[0];
    if (!wrWayAuto)        strobe.wrWay = wrWaySel;
    else if (!wrSetRefs[0]) strobe.wrWay = 1'b0;
    else if (!wrSetRefs[1]) strobe.wrWay = 1'b1;
    else                    strobe.wrWay = 1'b0;
  end

  a_r3_rsp_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    lkReq |=> rspValid);
  a_r4_miss_vpn: assert property (@(posedge clk) disable iff (!rstN)
    rspMiss |-> (rspMissVpn == $past(lkVa[VA_W-1:PAGE_W])));
  a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rstN)
    rspPaValid |-> (rspPa[PAGE_W-1:0] == $past(lkVa[PAGE_W-1:0])));
  a_r5_user_only: assert property (@(posedge clk) disable iff (!rstN)
    rspProtFault |-> ($past(lkUser) && !rspPaValid));
  a_r6_store_only: assert property (@(posedge clk) disable iff (!rstN)
    rspModFault |-> ($past(lkStore) && !rspPaValid));
endmodule

// File: rtl/sw_tlb.sv
module sw_tlb
  import sw_tlb_pkg::*;
#(
  parameter int VA_W   = 40,
  parameter int PA_W   = 36,
  parameter int PAGE_W = 14,
  parameter int SET_W  = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          lkReq,
  input  logic [VA_W-1:0]               lkVa,
  input  logic                          lkStore,
  input  logic                          lkUser,
  input  logic                          wrEn,
  input  logic [SET_W-1:0]              wrSet,
  input  logic                          wrWayAuto,
  input  logic                          wrWaySel,
  input  logic                          wrValid,
  input  logic                          wrDirty,
  input  logic [1:0]                    wrRights,
  input  logic [VA_W-PAGE_W-SET_W-1:0]  wrTag,
  input  logic [PA_W-PAGE_W-1:0]        wrPpn,
  input  logic                          invAll,
  input  logic                          clrRef,
  output logic                          rspValid,
  output logic                          rspHit,
  output logic                          rspMiss,
  output logic [VA_W-PAGE_W-1:0]        rspMissVpn,
  output logic                          rspProtFault,
  output logic                          rspModFault,
  output logic                          rspPaValid,
  output logic [PA_W-1:0]               rspPa,
  output logic                          rspWay,
  output logic [1:0]                    rspRights,
  output logic                          rspDirty
);
  localparam int VPN_W = VA_W - PAGE_W;
  localparam int TAG_W = VPN_W - SET_W;
  localparam int PPN_W = PA_W - PAGE_W;

  tlbStrobe_t          strobe;
  logic [SET_W-1:0]    lkSet;
  logic [TAG_W-1:0]    lkTag;
  logic [NUM_WAYS-1:0] hitVec, wrSetRefs;
  logic [PPN_W-1:0]    hitPpn;
  logic [1:0]          hitRights;
  logic                hitDirty;

  sw_tlb_ctrl #(.VA_W(VA_W), .PAGE_W(PAGE_W), .SET_W(SET_W), .PPN_W(PPN_W)) i_ctrl (
    .clk, .rstN, .lkReq, .lkVa, .lkStore, .lkUser, .wrEn, .wrWayAuto, .wrWaySel,
    .invAll, .clrRef, .wrSetRefs, .hitVec, .hitPpn, .hitRights, .hitDirty,
    .strobe, .lkSet, .lkTag, .rspValid, .rspHit, .rspMiss, .rspMissVpn,
    .rspProtFault, .rspModFault, .rspPaValid, .rspPa, .rspWay, .rspRights, .rspDirty
  );

  sw_tlb_store #(.SET_W(SET_W), .TAG_W(TAG_W), .PPN_W(PPN_W)) i_store (
    .clk, .rstN, .strobe, .wrSet, .wrValid, .wrDirty, .wrRights, .wrTag, .wrPpn,
    .lkSet, .lkTag, .hitVec, .wrSetRefs, .hitPpn, .hitRights, .hitDirty
  );
endmodule

// File: tb/test_sw_tlb.sv
module test_sw_tlb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lkReq = 1'b0, lkStore = 1'b0, lkUser = 1'b0;
  logic [39:0] lkVa = '0;
  logic        wrEn = 1'b0, wrWayAuto = 1'b0, wrWaySel = 1'b0, wrValid = 1'b0, wrDirty = 1'b0;
  logic [7:0]  wrSet = '0;
  logic [1:0]  wrRights = '0;
  logic [17:0] wrTag = '0;
  logic [21:0] wrPpn = '0;
  logic        invAll = 1'b0, clrRef = 1'b0;
  logic        rspValid, rspHit, rspMiss, rspProtFault, rspModFault, rspPaValid, rspWay, rspDirty;
  logic [25:0] rspMissVpn;
  logic [35:0] rspPa;
  logic [1:0]  rspRights;

  int checks = 0;
  int failures = 0;

  bit          mV   [256][2];
  bit          mD   [256][2];
  bit          mRef [256][2];
  logic [17:0] mTag [256][2];
  logic [21:0] mPpn [256][2];
  logic [1:0]  mR   [256][2];

  sw_tlb i_sw_tlb (.*);

  always #5 clk = ~clk;

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [39:0] mkVa(input logic [17:0] tag, input logic [7:0] s, input logic [13:0] off);
    return {tag, s, off};
  endfunction

  task automatic doWrite(input int s, input bit auto, input bit way, input bit v, input bit d,
                         input logic [1:0] r, input logic [17:0] tag, input logic [21:0] ppn);
    bit w;
    @(negedge clk);
    wrEn = 1; wrSet = 8'(s); wrWayAuto = auto; wrWaySel = way;
    wrValid = v; wrDirty = d; wrRights = r; wrTag = tag; wrPpn = ppn;
    // R8: automatic choice prefers a clear reference flag, way 0 first
    w = auto ? (!mRef[s][0] ? 1'b0 : (!mRef[s][1] ? 1'b1 : 1'b0)) : way;
    @(negedge clk);
    wrEn = 0;
    mV[s][w] = v; mD[s][w] = d; mR[s][w] = r; mTag[s][w] = tag; mPpn[s][w] = ppn; mRef[s][w] = 0;
  endtask

  task automatic doLookup(input logic [39:0] va, input bit st, input bit us, input string req);
    int s = int'(va[21:14]);
    bit h0 = mV[s][0] && mTag[s][0] == va[39:22];
    bit h1 = mV[s][1] && mTag[s][1] == va[39:22];
    bit hit = h0 || h1;
    bit hw = !h0;
    logic [1:0] r = mR[s][hw];
    bit prot = hit && us && (r == 2'b00 || r == 2'b11 || (r == 2'b01 && st));
    bit mdf = hit && !prot && st && !mD[s][hw];
    bit pav = hit && !prot && !mdf;
    logic [35:0] pa = pav ? {mPpn[s][hw], va[13:0]} : 36'h0;
    @(negedge clk);
    lkReq = 1; lkVa = va; lkStore = st; lkUser = us;
    @(negedge clk);
    lkReq = 0;
    check(req, "flags{valid,hit,miss,prot,mod,paValid}",
          {58'h0, rspValid, rspHit, rspMiss, rspProtFault, rspModFault, rspPaValid},
          {58'h0, 1'b1, hit, !hit, prot, mdf, pav});
    check(req, "rspPa", 64'(rspPa), 64'(pa));
    if (!hit) check(req, "rspMissVpn", 64'(rspMissVpn), 64'(va[39:14]));
    else check(req, "{way,rights,dirty}", {60'h0, rspWay, rspRights, rspDirty},
               {60'h0, hw, mR[s][hw], mD[s][hw]});
    if (hit) mRef[s][hw] = 1;
  endtask

  task automatic pulseClr();
    @(negedge clk); clrRef = 1;
    @(negedge clk); clrRef = 0;
    for (int i = 0; i < 256; i++) begin mRef[i][0] = 0; mRef[i][1] = 0; end
  endtask

  task automatic pulseInv();
    @(negedge clk); invAll = 1;
    @(negedge clk); invAll = 0;
    for (int i = 0; i < 256; i++) begin mV[i][0] = 0; mV[i][1] = 0; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++)
      for (int w = 0; w < 2; w++) begin
        mV[i][w] = 0; mD[i][w] = 0; mRef[i][w] = 0; mTag[i][w] = '0; mPpn[i][w] = '0; mR[i][w] = '0;
      end
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    // R13: idle after reset, R3: no response without request
    check("R13", "idle outputs", {60'h0, rspValid, rspHit, rspMiss, rspPaValid}, 64'h0);
    doLookup(mkVa(18'h5, 8'd3, 14'h11), 0, 1, "R13");

    // R7 / R2 / R1: explicit refill then hit
    doWrite(3, 0, 0, 1, 1, 2'b10, 18'h5, 22'h12345);
    doLookup(mkVa(18'h5, 8'd3, 14'h2abc), 0, 1, "R2");
    doLookup(mkVa(18'h6, 8'd3, 14'h0), 0, 1, "R4");
    doWrite(255, 0, 1, 1, 1, 2'b10, 18'h3ffff, 22'h3fffff);
    doLookup(40'hff_ffff_ffff, 1, 1, "R1");
    check("R1", "max pa", 64'(rspPa), 64'h0_0000_000f_ffff_ffff);

    // R5: rights table
    doWrite(4, 0, 0, 1, 1, 2'b01, 18'h7, 22'h100);
    doLookup(mkVa(18'h7, 8'd4, 14'h5), 1, 1, "R5");
    doLookup(mkVa(18'h7, 8'd4, 14'h5), 0, 1, "R5");
    doLookup(mkVa(18'h7, 8'd4, 14'h5), 1, 0, "R5");
    doWrite(4, 0, 0, 1, 1, 2'b00, 18'h7, 22'h100);
    doLookup(mkVa(18'h7, 8'd4, 14'h5), 0, 1, "R5");
    doWrite(4, 0, 1, 1, 1, 2'b11, 18'h8, 22'h200);
    doLookup(mkVa(18'h8, 8'd4, 14'h6), 0, 1, "R5");
    doLookup(mkVa(18'h8, 8'd4, 14'h6), 0, 0, "R5");
    check("R5", "kernel granted way1", {62'h0, rspPaValid, rspWay}, 64'h3);

    // R6: modify trap
    doWrite(5, 0, 0, 1, 0, 2'b10, 18'h9, 22'h300);
    doLookup(mkVa(18'h9, 8'd5, 14'h7), 1, 1, "R6");
    check("R6", "mod trap", 64'(rspModFault), 64'h1);
    doLookup(mkVa(18'h9, 8'd5, 14'h7), 0, 1, "R6");

    // R8 / R9 / R10: reference flags steer automatic refill
    pulseClr();
    doWrite(10, 1, 0, 1, 1, 2'b10, 18'h20, 22'h20);
    doLookup(mkVa(18'h20, 8'd10, 14'h0), 0, 0, "R8");
    check("R8", "first auto way", 64'(rspWay), 64'h0);
    doWrite(10, 1, 0, 1, 1, 2'b10, 18'h21, 22'h21);
    doLookup(mkVa(18'h21, 8'd10, 14'h0), 0, 0, "R9");
    check("R9", "auto after hit in way0", 64'(rspWay), 64'h1);
    doWrite(10, 1, 0, 1, 1, 2'b10, 18'h22, 22'h22);
    doLookup(mkVa(18'h22, 8'd10, 14'h0), 0, 0, "R8");
    check("R8", "both flags set -> way0", 64'(rspWay), 64'h0);
    doLookup(mkVa(18'h21, 8'd10, 14'h0), 0, 0, "R9");
    pulseClr();
    doWrite(10, 1, 0, 1, 1, 2'b10, 18'h23, 22'h23);
    doLookup(mkVa(18'h23, 8'd10, 14'h0), 0, 0, "R10");
    check("R10", "auto after clear", 64'(rspWay), 64'h0);

    // R12: refill overlapping the response cycle
    doWrite(12, 0, 0, 1, 1, 2'b10, 18'h30, 22'h30);
    @(negedge clk);
    lkReq = 1; lkVa = mkVa(18'h31, 8'd12, 14'h44); lkStore = 0; lkUser = 1;
    @(negedge clk);
    lkReq = 0;
    wrEn = 1; wrSet = 8'd12; wrWayAuto = 0; wrWaySel = 0; wrValid = 1; wrDirty = 1;
    wrRights = 2'b10; wrTag = 18'h31; wrPpn = 22'h2a2a2;
    #1;
    check("R12", "forwarded hit", {63'h0, rspHit}, 64'h1);
    check("R12", "forwarded pa", 64'(rspPa), 64'({22'h2a2a2, 14'h44}));
    @(negedge clk);
    wrEn = 0;
    mV[12][0] = 1; mD[12][0] = 1; mR[12][0] = 2'b10; mTag[12][0] = 18'h31; mPpn[12][0] = 22'h2a2a2; mRef[12][0] = 0;
    doLookup(mkVa(18'h31, 8'd12, 14'h1), 0, 1, "R12");

    // R11: invalidate, and invalidate beating a refill
    pulseInv();
    doLookup(mkVa(18'h5, 8'd3, 14'h0), 0, 1, "R11");
    @(negedge clk);
    invAll = 1; wrEn = 1; wrSet = 8'd6; wrWayAuto = 0; wrWaySel = 0; wrValid = 1;
    wrDirty = 1; wrRights = 2'b10; wrTag = 18'h40; wrPpn = 22'h40;
    @(negedge clk);
    invAll = 0; wrEn = 0;
    mTag[6][0] = 18'h40; mPpn[6][0] = 22'h40; mR[6][0] = 2'b10; mD[6][0] = 1; mRef[6][0] = 0;
    doLookup(mkVa(18'h40, 8'd6, 14'h0), 0, 1, "R11");

    // random mix
    void'($urandom(32'h1d5e_a7e1));
    for (int n = 0; n < 600; n++) begin
      int op = int'($urandom % 12);
      int s;
      case ($urandom % 4) 0: s = 0; 1: s = 1; 2: s = 2; default: s = 255; endcase
      if (op < 3)
        doWrite(s, 1'($urandom), 1'($urandom), ($urandom % 8) != 0, 1'($urandom),
                2'($urandom), 18'($urandom % 4), 22'($urandom));
      else if (op == 11) pulseClr();
      else doLookup(mkVa(18'($urandom % 4), 8'(s), 14'($urandom)), 1'($urandom), 1'($urandom), "R2");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule